// File: doc/BRIEF.md
# Duty-Cycle Bit Decoder

This block receives commands from a two-level voltage bus. It sees the bus only through two comparator outputs that are already digitized and synchronized. One of them is `sigHigh`, which shows whether the bus is above the signal threshold. The other is `frameHigh`, which shows whether the bus is above the higher frame threshold.

Each bit starts when the bus drops below the signal threshold. The block counts clock cycles spent low, then cycles spent high. The bit ends when the bus drops again, or when the frame ends. The bit value comes from comparing the two counts. No baud clock is involved, so the block accepts any bit period that fits its counters.

The decoded bits are shifted into a command word. A frame ends when the bus rises above the frame threshold. At that point the block checks the number of bits against the count expected by the command decoder (`reqBits`). It then publishes the word with a valid strobe, or raises an error strobe instead. If the bus stays below the frame threshold for too long, the block treats the link as lost. It raises a reset request and drops any partial frame.

Top module: `dutybit_decoder`

## Requirements
- R1: After reset, `cmdWord` is zero and `frameValid`, `frameErr` and `lossReset` are low.
- R2: A bit decodes as 1 when its high-cycle count is strictly greater than its low-cycle count, and as 0 otherwise. Equal counts give 0.
- R3: Bits enter the word first-received in the most significant position. A frame of N bits leaves them in `cmdWord[N-1:0]`, and the upper bits are zero.
- R4: A bit's low count covers the consecutive samples with `sigHigh`=0 from its first low sample. Its high count covers the following samples with `sigHigh`=1. A sample with `sigHigh`=0 after a high phase closes the bit and starts the next one. Results depend only on these counts, whatever the bit period.
- R5: A sample with `frameHigh`=1 during a high phase closes the last bit and ends the frame. If the bit count equals `reqBits` (and `reqBits` ≤ CMD_W), `cmdWord` takes the new word and `frameValid` pulses for exactly one cycle, both in the cycle after that sample.
- R6: If the bit count differs from `reqBits`, `frameErr` pulses for one cycle instead, `frameValid` stays low and `cmdWord` keeps its previous value.
- R7: A frame with more than CMD_W bits is always reported through `frameErr`.
- R8: The low and high counters saturate at 2^CNT_W−1 and do not wrap.
- R9: `lossReset` goes high after TIMEOUT_CYC consecutive samples with `frameHigh`=0, and not before. It stays high until the first sample with `frameHigh`=1.
- R10: A frame cut off by `lossReset` is discarded. The following rise of `frameHigh` produces neither `frameValid` nor `frameErr`.
- R11: While idle, a rise of `frameHigh` with no preceding bit produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rstN | input | 1 | Active-low synchronous reset |
| sigHigh | input | 1 | Bus above signal threshold |
| frameHigh | input | 1 | Bus above frame threshold |
| reqBits | input | $clog2(CMD_W+2) | Bit count required for the current command |
| cmdWord | output | CMD_W | Last accepted command word |
| frameValid | output | 1 | One-cycle strobe: frame accepted |
| frameErr | output | 1 | One-cycle strobe: bit count mismatch |
| lossReset | output | 1 | Bus-loss reset request |

## Verification
The assertions assume that both comparator inputs are synchronous to `clk`. They also assume that `reqBits` is steady at the cycle where a frame closes. The bench changes inputs only on falling edges and holds `reqBits` for the whole frame. Apart from the deliberate timeout cases, the bench keeps every frame shorter than TIMEOUT_CYC. During frames it keeps `frameHigh` low whenever `sigHigh` is low, which matches the physical ordering of the two thresholds.

// File: rtl/dutybit_pkg.sv
package dutybit_pkg;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_LOW  = 2'd1,
    S_HIGH = 2'd2
  } dec_state_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic startFrame;  // clear shift register and bit count
    logic startLow;    // first low sample of a bit
    logic incLow;      // further low sample
    logic startHigh;   // first high sample of a bit
    logic incHigh;     // further high sample
    logic bitDone;     // shift decoded bit in
    logic frameDone;   // evaluate frame
  } dec_ctl_t;

endpackage

// File: rtl/dutybit_ctrl.sv
module dutybit_ctrl
  import dutybit_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     sigHigh,
  input  logic     frameHigh,
  input  logic     lossHit,
  output dec_ctl_t ctl
);

  dec_state_t state, stateNext;

  always_comb begin
    ctl = '0;
    stateNext = state;
    unique case (state)
      S_IDLE: begin
        if (!lossHit && !sigHigh) begin
          ctl.startFrame = 1'b1;
          ctl.startLow = 1'b1;
          stateNext = S_LOW;
        end
      end
      S_LOW: begin
        if (lossHit) begin
          stateNext = S_IDLE;
        end else if (!sigHigh) begin
          ctl.incLow = 1'b1;
        end else begin
          ctl.startHigh = 1'b1;
          stateNext = S_HIGH;
        end
      end
      S_HIGH: begin
        if (lossHit) begin
          stateNext = S_IDLE;
        end else if (frameHigh) begin
          ctl.bitDone = 1'b1;
          ctl.frameDone = 1'b1;
          stateNext = S_IDLE;
        end else if (!sigHigh) begin
          ctl.bitDone = 1'b1;
          ctl.startLow = 1'b1;
          stateNext = S_LOW;
        end else begin
          ctl.incHigh = 1'b1;
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  AST_LOSS_TO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    lossHit |=> (state == S_IDLE)); // R10

  AST_IDLE_NO_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE) |-> !ctl.frameDone); // R11

endmodule

// File: rtl/dutybit_dpath.sv
module dutybit_dpath
  import dutybit_pkg::*;
#(
  parameter int CMD_W       = 16,
  parameter int CNT_W       = 8,
  parameter int TIMEOUT_CYC = 2000,
  localparam int BC_W = $clog2(CMD_W + 2),
  localparam int TO_W = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameHigh,
  input  logic [BC_W-1:0]  reqBits,
  input  dec_ctl_t         ctl,
  output logic             lossHit,
  output logic [CMD_W-1:0] cmdWord,
  output logic             frameValid,
  output logic             frameErr
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [BC_W-1:0]  BC_SAT  = BC_W'(CMD_W + 1);
  localparam logic [BC_W-1:0]  BC_FULL = BC_W'(CMD_W);
  localparam logic [TO_W-1:0]  TO_LIM  = TO_W'(TIMEOUT_CYC);

  logic [CNT_W-1:0] lowCnt, highCnt;
  logic [CMD_W-1:0] shiftReg, shiftNext;
  logic [BC_W-1:0]  bitCnt, bitCntNext;
  logic [TO_W-1:0]  toCnt;
  logic             bitVal, countOk;

  assign bitVal     = highCnt > lowCnt;
  assign shiftNext  = {shiftReg[CMD_W-2:0], bitVal};
  assign bitCntNext = (bitCnt == BC_SAT) ? BC_SAT : bitCnt + 1'b1;
  assign countOk    = (bitCntNext == reqBits) && (reqBits <= BC_FULL);
  assign lossHit    = (toCnt == TO_LIM);

  // Phase counters
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowCnt  <= '0;
      highCnt <= '0;
    end else begin
      if (ctl.startLow) begin
        lowCnt  <= CNT_W'(1);
        highCnt <= '0;
      end else if (ctl.incLow && lowCnt != CNT_MAX) begin
        lowCnt <= lowCnt + 1'b1;
      end
      if (ctl.startHigh) begin
        highCnt <= CNT_W'(1);
      end else if (ctl.incHigh && highCnt != CNT_MAX) begin
        highCnt <= highCnt + 1'b1;
      end
    end
  end

  // Shift register and bit count
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
    end else if (ctl.startFrame) begin
      shiftReg <= '0;
      bitCnt   <= '0;
    end else if (ctl.bitDone) begin
      shiftReg <= shiftNext;
      bitCnt   <= bitCntNext;
    end
  end

  // Frame evaluation
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdWord    <= '0;
      frameValid <= 1'b0;
      frameErr   <= 1'b0;
    end else begin
      frameValid <= 1'b0;
      frameErr   <= 1'b0;
      if (ctl.frameDone) begin
        if (countOk) begin
          cmdWord    <= shiftNext;
          frameValid <= 1'b1;
        end else begin
          frameErr <= 1'b1;
        end
      end
    end
  end

  // Bus-loss timer
  always_ff @(posedge clk) begin
    if (!rstN)               toCnt <= '0;
    else if (frameHigh)      toCnt <= '0;
    else if (toCnt != TO_LIM) toCnt <= toCnt + 1'b1;
  end

  AST_LOW_SAT: assert property (@(posedge clk) disable iff (!rstN)
    (lowCnt == CNT_MAX && ctl.incLow) |=> (lowCnt == CNT_MAX)); // R8

  AST_HIGH_SAT: assert property (@(posedge clk) disable iff (!rstN)
    (highCnt == CNT_MAX && ctl.incHigh) |=> (highCnt == CNT_MAX)); // R8

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    frameValid |=> !frameValid); // R5

  AST_WORD_ONLY_ON_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cmdWord) |-> frameValid); // R5

  AST_ERR_KEEPS_WORD: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |-> $stable(cmdWord)); // R6

  AST_LOSS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lossHit) |-> !$past(frameHigh)); // R9

endmodule

// File: rtl/dutybit_decoder.sv
module dutybit_decoder
  import dutybit_pkg::*;
#(
  parameter int CMD_W       = 16,
  parameter int CNT_W       = 8,
  parameter int TIMEOUT_CYC = 2000,
  localparam int BC_W = $clog2(CMD_W + 2)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sigHigh,
  input  logic             frameHigh,
  input  logic [BC_W-1:0]  reqBits,
  output logic [CMD_W-1:0] cmdWord,
  output logic             frameValid,
  output logic             frameErr,
  output logic             lossReset
);

  dec_ctl_t ctl;
  logic     lossHit;

  dutybit_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .sigHigh   (sigHigh),
    .frameHigh (frameHigh),
    .lossHit   (lossHit),
    .ctl       (ctl)
  );

  dutybit_dpath #(
    .CMD_W       (CMD_W),
    .CNT_W       (CNT_W),
    .TIMEOUT_CYC (TIMEOUT_CYC)
  ) uDpath (
    .clk        (clk),
    .rstN       (rstN),
    .frameHigh  (frameHigh),
    .reqBits    (reqBits),
    .ctl        (ctl),
    .lossHit    (lossHit),
    .cmdWord    (cmdWord),
    .frameValid (frameValid),
    .frameErr   (frameErr)
  );

  assign lossReset = lossHit;

  AST_NO_DOUBLE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !(frameValid && frameErr)); // R6

endmodule

// File: tb/dutybit_decoder_test.sv
module dutybit_decoder_test;

  localparam int CMD_W = 16;
  localparam int CNT_W = 4;
  localparam int TO    = 300;
  localparam int BC_W  = $clog2(CMD_W + 2);

  logic             clk = 1'b0;
  logic             rstN;
  logic             sigHigh;
  logic             frameHigh;
  logic [BC_W-1:0]  reqBits;
  logic [CMD_W-1:0] cmdWord;
  logic             frameValid, frameErr, lossReset;

  int total = 0;
  int bad = 0;
  logic [CMD_W-1:0] expCmd;

  always #4 clk = ~clk;

  dutybit_decoder #(.CMD_W(CMD_W), .CNT_W(CNT_W), .TIMEOUT_CYC(TO)) uut (
    .clk(clk), .rstN(rstN), .sigHigh(sigHigh), .frameHigh(frameHigh),
    .reqBits(reqBits), .cmdWord(cmdWord), .frameValid(frameValid),
    .frameErr(frameErr), .lossReset(lossReset)
  );

  // {nbits[33:29], req[28:24], data[23:8], short[7:4], long[3:0]}
  localparam logic [33:0] VECS [7] = '{
    {5'd8,  5'd8,  16'h00A5, 4'd2, 4'd4},
    {5'd16, 5'd16, 16'hC3F0, 4'd1, 4'd2},
    {5'd12, 5'd12, 16'h05A3, 4'd3, 4'd7},
    {5'd5,  5'd6,  16'h0015, 4'd2, 4'd4},
    {5'd17, 5'd16, 16'hFFFF, 4'd1, 4'd3},
    {5'd1,  5'd1,  16'h0001, 4'd4, 4'd5},
    {5'd16, 5'd16, 16'h0000, 4'd5, 4'd9}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input logic s, input int n);
    sigHigh = s;
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(input int lowN, input int highN);
    hold(1'b0, lowN);
    hold(1'b1, highN);
  endtask

  task automatic openFrame();
    frameHigh = 1'b0;
    hold(1'b1, 2);
  endtask

  // Raise frame; sample strobes in the cycle after
  task automatic closeFrame(output logic v, output logic e);
    frameHigh = 1'b1;
    @(negedge clk);
    v = frameValid;
    e = frameErr;
  endtask

  initial begin
    int seen;
    logic v, e;
    rstN = 1'b0; sigHigh = 1'b1; frameHigh = 1'b1; reqBits = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cmdWord", 32'(cmdWord), 0);
    chk("R1 strobes", {frameValid, frameErr, lossReset}, 0);
    expCmd = '0;

    // Vector table: R2 R3 R4 R5 R6 R7
    foreach (VECS[k]) begin
      int nb, rq, ts, tl;
      logic [15:0] dat;
      logic expOk;
      nb = int'(VECS[k][33:29]); rq = int'(VECS[k][28:24]);
      dat = VECS[k][23:8]; ts = int'(VECS[k][7:4]); tl = int'(VECS[k][3:0]);
      reqBits = BC_W'(rq);
      openFrame();
      for (int i = nb - 1; i >= 0; i--) begin
        logic b;
        b = (i < 16) ? dat[i] : 1'b0;
        if (b) sendBit(ts, tl); else sendBit(tl, ts);
      end
      closeFrame(v, e);
      expOk = (nb == rq) && (rq <= CMD_W);
      if (expOk) expCmd = dat & 16'((32'd1 << nb) - 1);
      chk(expOk ? "R5 valid" : (nb > CMD_W ? "R7 valid" : "R6 valid"), 32'(v), 32'(expOk));
      chk(expOk ? "R5 err" : (nb > CMD_W ? "R7 err" : "R6 err"), 32'(e), 32'(!expOk));
      chk(expOk ? "R3 cmdWord" : "R6 cmdWord", 32'(cmdWord), 32'(expCmd));
      @(negedge clk);
      chk("R5 one-cycle pulse", {frameValid, frameErr}, 0);
    end

    // R2 equal counts -> 0: bits (3,3)=0, (2,4)=1, (4,4)=0
    reqBits = BC_W'(3);
    openFrame();
    sendBit(3, 3); sendBit(2, 4); sendBit(4, 4);
    closeFrame(v, e);
    chk("R2 equal valid", 32'(v), 1);
    chk("R2 equal word", 32'(cmdWord), 32'h2);

    // R8 saturation: (18,25)->0 (both sat), (10,25)->1
    reqBits = BC_W'(2);
    openFrame();
    sendBit(18, 25); sendBit(10, 25);
    closeFrame(v, e);
    chk("R8 sat valid", 32'(v), 1);
    chk("R8 sat word", 32'(cmdWord), 32'h1);
    expCmd = 16'h1;

    // R11 frame threshold pulse with no bits
    repeat (2) @(negedge clk);
    frameHigh = 1'b0;
    repeat (3) @(negedge clk);
    closeFrame(v, e);
    chk("R11 no strobe", {v, e}, 0);
    chk("R11 word kept", 32'(cmdWord), 32'(expCmd));

    // R9 timeout boundary
    @(negedge clk);
    frameHigh = 1'b0;
    repeat (TO - 1) @(negedge clk);
    chk("R9 not yet", 32'(lossReset), 0);
    @(negedge clk);
    chk("R9 asserted", 32'(lossReset), 1);
    repeat (3) @(negedge clk);
    chk("R9 held", 32'(lossReset), 1);
    frameHigh = 1'b1;
    @(negedge clk);
    chk("R9 cleared", 32'(lossReset), 0);

    // R10 frame cut by timeout is discarded
    reqBits = BC_W'(2);
    openFrame();
    sendBit(2, 4); sendBit(2, 4);
    seen = 0;
    for (int i = 0; i < TO + 10 && seen == 0; i++) begin
      if (lossReset) seen = 1; else @(negedge clk);
    end
    chk("R10 timeout seen", 32'(seen), 1);
    closeFrame(v, e);
    chk("R10 no strobe", {v, e}, 0);
    chk("R10 word kept", 32'(cmdWord), 32'(expCmd));

    // Recovery after loss
    repeat (2) @(negedge clk);
    reqBits = BC_W'(4);
    openFrame();
    sendBit(1, 2); sendBit(2, 1); sendBit(1, 2); sendBit(1, 2);
    closeFrame(v, e);
    chk("R4 recovery valid", 32'(v), 1);
    chk("R4 recovery word", 32'(cmdWord), 32'hB);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule